// File: doc/BRIEF.md
# Column-Serial Snapshot Readout Chain

This block is the observation path of a two-dimensional array of processing elements. Every element holds a snapshot register. A global capture strobe freezes three quantities from each element into its register in one cycle: its accumulator value, its fire count, and how many fire events wait in its delay queue. The elements of one column are linked from bottom to top into a single serial chain. On each global shift strobe, every register moves one bit toward the element above it. The bit that leaves the top of a column is placed into that column's position in an output word. A readout therefore costs one shift per bit row, whatever the number of columns, and no shared bus spans the array.

The strobes act on every element, whether or not the element has been given a function. This lets a controller take a snapshot after any network step, whether the array is running or paused. It then shifts the snapshot out one word per strobe. Each element yields 32 bits, most significant first. The top element of a column empties first, then the one below it.

Top module: `snap_chain_monitor`

## Requirements
- R1: After reset the output word is all zero and the word-valid flag is low.
- R2: A capture strobe loads every element's register with {accumulator (8 bits), fire count (16 bits), queue fill (8 bits, 0 to 128)}, with the accumulator in bits 31:24 and the queue fill in bits 7:0. The accumulator MSB therefore leaves the chain first.
- R3: A shift strobe without capture makes, one cycle later, bit c of the word equal to the bit that left the top of column c, and raises word-valid for exactly that cycle.
- R4: Within a column, the top element's 32 bits come out first, then the element below it, and so on. A full column of ROWS elements is read in 32*ROWS shifts.
- R5: The bottom element of each column shifts in zero. Shifts beyond 32*ROWS since the last capture yield all-zero words.
- R6: When capture and shift are asserted in the same cycle, the capture is performed and no bit moves. Word-valid stays low and the word keeps its previous value.
- R7: Word bits at positions COLS and above are always zero.
- R8: A capture during a readout discards the remaining old bits. The next shift starts the new snapshot from its first bit.
- R9: In a cycle with neither strobe, the word holds its value, word-valid is low, and the chain does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_i | input | 1 | Global capture strobe |
| shift_i | input | 1 | Global shift strobe |
| acc_flat_i | input | ROWS*COLS*ACC_W | Accumulator of element (r,c) at slice index r*COLS+c, row 0 at the bottom |
| cnt_flat_i | input | ROWS*COLS*CNT_W | Fire count per element, same indexing |
| fill_flat_i | input | ROWS*COLS*FILL_W | Delay-queue fill per element, same indexing |
| word_o | output | WORD_W | One bit per column from the latest shift |
| word_valid_o | output | 1 | High in the cycle after a shift that moved the chain |

## Verification
Every strobe takes effect at the clock edge on which it is sampled. The word and word-valid produced by a shift are therefore visible one cycle after the shift is presented, and a capture shows up first in the word of the next shift. The bench drives strobes on the falling edge and advances its reference model at the rising edge. It compares word and valid on the following falling edge, so each result is checked in exactly the cycle it is due. Dedicated checks also rebuild the full 32-bit fields of chosen columns from consecutive words.

// File: rtl/mon_snap_pkg.sv
package mon_snap_pkg;
   localparam int unsigned DEF_ACC_W    = 8;
   localparam int unsigned DEF_CNT_W    = 16;
   localparam int unsigned DEF_FILL_W   = 8;
   localparam int unsigned DEF_FILL_MAX = 128;
   localparam int unsigned DEF_WORD_W   = 128;

   // bits needed to represent values 0..maxval
   function automatic int unsigned bits_for(input int unsigned maxval);
      return $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/mon_snap_cell.sv
module mon_snap_cell #(
   parameter int unsigned ACC_W  = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned FILL_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cap_i,
   input  logic                            shf_i,
   input  logic [ACC_W-1:0]                acc_i,
   input  logic [CNT_W-1:0]                cnt_i,
   input  logic [FILL_W-1:0]               fill_i,
   input  logic                            ser_i,
   output logic                            ser_o,
   output logic [ACC_W+CNT_W+FILL_W-1:0]   snap_o
);
   localparam int unsigned SNAP_W = ACC_W + CNT_W + FILL_W;

   logic [SNAP_W-1:0] snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         snap_q <= '0;
      else if (cap_i)
         snap_q <= {acc_i, cnt_i, fill_i};
      else if (shf_i)
         snap_q <= {snap_q[SNAP_W-2:0], ser_i};
   end

   assign ser_o  = snap_q[SNAP_W-1];
   assign snap_o = snap_q;

   // R2: capture loads the three fields in order
   p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> snap_q == $past({acc_i, cnt_i, fill_i}));

   // R9: no strobe, no movement
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !shf_i) |=> $stable(snap_q));
endmodule

// File: rtl/mon_snap_column.sv
module mon_snap_column #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned ACC_W  = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned FILL_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic                    shf_i,
   input  logic [ROWS*ACC_W-1:0]   acc_i,
   input  logic [ROWS*CNT_W-1:0]   cnt_i,
   input  logic [ROWS*FILL_W-1:0]  fill_i,
   output logic                    top_o
);
   localparam int unsigned SNAP_W = ACC_W + CNT_W + FILL_W;

   logic [ROWS-1:0]   link;
   logic [ROWS-1:0]   feed;
   logic [SNAP_W-1:0] snap_arr [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r == 0) begin : g_bottom
         assign feed[r] = 1'b0;
      end else begin : g_link
         assign feed[r] = link[r-1];

         // R4: each element takes the bit leaving the one below
         p_chain_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (shf_i && !cap_i) |=> snap_arr[r][0] == $past(snap_arr[r-1][SNAP_W-1]));
      end

      mon_snap_cell #(
         .ACC_W (ACC_W),
         .CNT_W (CNT_W),
         .FILL_W(FILL_W)
      ) cell_i (
         .clk   (clk),
         .rst_n (rst_n),
         .cap_i (cap_i),
         .shf_i (shf_i),
         .acc_i (acc_i[r*ACC_W +: ACC_W]),
         .cnt_i (cnt_i[r*CNT_W +: CNT_W]),
         .fill_i(fill_i[r*FILL_W +: FILL_W]),
         .ser_i (feed[r]),
         .ser_o (link[r]),
         .snap_o(snap_arr[r])
      );
   end

   assign top_o = link[ROWS-1];

   // R5: the bottom of the column fills with zero
   p_bottom_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_i && !cap_i) |=> snap_arr[0][0] == 1'b0);
endmodule

// File: rtl/mon_word_collect.sv
module mon_word_collect #(
   parameter int unsigned COLS   = 8,
   parameter int unsigned WORD_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              shf_i,
   input  logic [COLS-1:0]   top_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);
   logic [COLS-1:0] word_q;
   logic            valid_q;
   logic            move;

   assign move = shf_i && !cap_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= move;
         if (move)
            word_q <= top_i;
      end
   end

   if (COLS < WORD_W) begin : g_pad
      assign word_o = {{(WORD_W-COLS){1'b0}}, word_q};
   end else begin : g_full
      assign word_o = word_q;
   end
   assign valid_o = valid_q;

   // R3: a moving shift produces a valid word holding the top bits
   p_valid_after_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_i && !cap_i) |=> valid_o);
   p_word_tracks_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shf_i && !cap_i) |=> word_o[COLS-1:0] == $past(top_i));
   // R6: capture suppresses the shift
   p_capture_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (!valid_o && $stable(word_o)));
   // R9: word holds without a moving shift
   p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(shf_i && !cap_i) |=> (!valid_o && $stable(word_o)));
endmodule

// File: rtl/snap_chain_monitor.sv
module snap_chain_monitor
   import mon_snap_pkg::*;
#(
   parameter int unsigned ROWS     = 4,
   parameter int unsigned COLS     = 8,
   parameter int unsigned ACC_W    = DEF_ACC_W,
   parameter int unsigned CNT_W    = DEF_CNT_W,
   parameter int unsigned FILL_MAX = DEF_FILL_MAX,
   parameter int unsigned FILL_W   = DEF_FILL_W,
   parameter int unsigned WORD_W   = DEF_WORD_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         capture_i,
   input  logic                         shift_i,
   input  logic [ROWS*COLS*ACC_W-1:0]   acc_flat_i,
   input  logic [ROWS*COLS*CNT_W-1:0]   cnt_flat_i,
   input  logic [ROWS*COLS*FILL_W-1:0]  fill_flat_i,
   output logic [WORD_W-1:0]            word_o,
   output logic                         word_valid_o
);
   localparam int unsigned FILL_NEED = bits_for(FILL_MAX);

   if (COLS > WORD_W) begin : g_chk_cols
      $error("COLS must not exceed WORD_W");
   end
   if (FILL_W < FILL_NEED) begin : g_chk_fill
      $error("FILL_W too narrow for FILL_MAX");
   end
   if (ROWS < 1 || COLS < 1) begin : g_chk_dims
      $error("array needs at least one row and one column");
   end

   logic [ROWS*ACC_W-1:0]  col_acc  [COLS];
   logic [ROWS*CNT_W-1:0]  col_cnt  [COLS];
   logic [ROWS*FILL_W-1:0] col_fill [COLS];
   logic [COLS-1:0]        top_bits;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar r = 0; r < ROWS; r++) begin : g_el
         localparam int unsigned IDX = r*COLS + c;
         assign col_acc[c][r*ACC_W +: ACC_W]    = acc_flat_i[IDX*ACC_W +: ACC_W];
         assign col_cnt[c][r*CNT_W +: CNT_W]    = cnt_flat_i[IDX*CNT_W +: CNT_W];
         assign col_fill[c][r*FILL_W +: FILL_W] = fill_flat_i[IDX*FILL_W +: FILL_W];
      end

      mon_snap_column #(
         .ROWS  (ROWS),
         .ACC_W (ACC_W),
         .CNT_W (CNT_W),
         .FILL_W(FILL_W)
      ) col_i (
         .clk   (clk),
         .rst_n (rst_n),
         .cap_i (capture_i),
         .shf_i (shift_i),
         .acc_i (col_acc[c]),
         .cnt_i (col_cnt[c]),
         .fill_i(col_fill[c]),
         .top_o (top_bits[c])
      );
   end

   mon_word_collect #(
      .COLS  (COLS),
      .WORD_W(WORD_W)
   ) collect_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (capture_i),
      .shf_i  (shift_i),
      .top_i  (top_bits),
      .word_o (word_o),
      .valid_o(word_valid_o)
   );
endmodule

// File: tb/snap_chain_monitor_tb.sv
module snap_chain_monitor_tb_top;
   localparam int ROWS   = 4;
   localparam int COLS   = 8;
   localparam int ACC_W  = 8;
   localparam int CNT_W  = 16;
   localparam int FILL_W = 8;
   localparam int WORD_W = 128;
   localparam int SW     = ACC_W + CNT_W + FILL_W;
   localparam int TOT    = ROWS * SW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic capture = 1'b0;
   logic shift = 1'b0;
   logic [ROWS*COLS*ACC_W-1:0]  acc_flat  = '0;
   logic [ROWS*COLS*CNT_W-1:0]  cnt_flat  = '0;
   logic [ROWS*COLS*FILL_W-1:0] fill_flat = '0;
   logic [WORD_W-1:0] word;
   logic              word_valid;

   always #5 clk = ~clk;

   snap_chain_monitor #(
      .ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W), .CNT_W(CNT_W),
      .FILL_MAX(128), .FILL_W(FILL_W), .WORD_W(WORD_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .capture_i(capture), .shift_i(shift),
      .acc_flat_i(acc_flat), .cnt_flat_i(cnt_flat), .fill_flat_i(fill_flat),
      .word_o(word), .word_valid_o(word_valid)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   // reference model: per-column bit stream, read index shared by all columns
   logic [TOT-1:0]    mdl [COLS];
   int                rd = TOT;
   logic [WORD_W-1:0] exp_word = '0;
   logic              exp_valid = 1'b0;

   function automatic logic [SW-1:0] elem_snap(int r, int c);
      int idx = r*COLS + c;
      return {acc_flat[idx*ACC_W +: ACC_W], cnt_flat[idx*CNT_W +: CNT_W],
              fill_flat[idx*FILL_W +: FILL_W]};
   endfunction

   task automatic load_pattern(int seed);
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            int idx = r*COLS + c;
            if (seed == 3) begin
               acc_flat[idx*ACC_W +: ACC_W]    = 8'hFF;
               cnt_flat[idx*CNT_W +: CNT_W]    = 16'hFFFF;
               fill_flat[idx*FILL_W +: FILL_W] = 8'd128;
            end else begin
               acc_flat[idx*ACC_W +: ACC_W]    = 8'((seed*37 + r*11 + c*5 + 1) & 255);
               cnt_flat[idx*CNT_W +: CNT_W]    = 16'((seed*4099 + r*257 + c*3) & 65535);
               fill_flat[idx*FILL_W +: FILL_W] = 8'((seed*13 + r*7 + c) % 129);
            end
         end
      end
   endtask

   task automatic compare();
      checks++;
      if (word !== exp_word || word_valid !== exp_valid) begin
         errors++;
         $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                  cur_req, word, word_valid, exp_word, exp_valid);
      end
   endtask

   task automatic step(logic cap, logic shf);
      capture = cap;
      shift   = shf;
      @(posedge clk);
      if (!rst_n) begin
         exp_word  = '0;
         exp_valid = 1'b0;
         rd        = TOT;
      end else if (cap) begin
         for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++)
               mdl[c][r*SW +: SW] = elem_snap(r, c);
         end
         rd        = 0;
         exp_valid = 1'b0;
      end else if (shf) begin
         for (int c = 0; c < COLS; c++)
            exp_word[c] = (rd < TOT) ? mdl[c][TOT-1-rd] : 1'b0;
         if (rd < TOT) rd++;
         exp_valid = 1'b1;
      end else begin
         exp_valid = 1'b0;
      end
      @(negedge clk);
      compare();
   endtask

   task automatic check_field(string req, logic [SW-1:0] got, logic [SW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: field=%h expected %h", req, got, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [SW-1:0] got0, got7;
      @(negedge clk);
      cur_req = "R1";
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
      compare();

      // R2 / R4: capture and read out fully, assembling fields
      load_pattern(1);
      cur_req = "R2";
      step(1'b1, 1'b0);
      load_pattern(9);        // inputs change after capture: must not matter
      for (int i = 0; i < SW; i++) begin
         step(1'b0, 1'b1);
         got0 = {got0[SW-2:0], word[0]};
         got7 = {got7[SW-2:0], word[COLS-1]};
      end
      load_pattern(1);
      check_field("R2", got0, elem_snap(ROWS-1, 0));
      check_field("R2", got7, elem_snap(ROWS-1, COLS-1));
      cur_req = "R4";
      for (int i = 0; i < SW; i++) begin
         step(1'b0, 1'b1);
         got0 = {got0[SW-2:0], word[1]};
      end
      check_field("R4", got0, elem_snap(ROWS-2, 1));
      load_pattern(9);
      for (int i = 0; i < 2*SW; i++) step(1'b0, 1'b1);
      cur_req = "R5";
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1);

      // R9: idle gaps
      cur_req = "R9";
      load_pattern(2);
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1);

      // R7: upper word bits stay zero with all-ones data
      cur_req = "R7";
      load_pattern(3);
      step(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1);
         checks++;
         if (word[WORD_W-1:COLS] !== '0) begin
            errors++;
            $display("FAIL R7: upper=%h expected 0", word[WORD_W-1:COLS]);
         end
      end

      // R6: capture and shift together
      cur_req = "R6";
      load_pattern(4);
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

      // R8: capture in the middle of a readout
      cur_req = "R8";
      load_pattern(5);
      step(1'b1, 1'b0);
      for (int i = 0; i < 17; i++) step(1'b0, 1'b1);
      load_pattern(6);
      step(1'b1, 1'b0);
      for (int i = 0; i < SW; i++) begin
         step(1'b0, 1'b1);
         got0 = {got0[SW-2:0], word[3]};
      end
      check_field("R8", got0, elem_snap(ROWS-1, 3));
      cur_req = "R3";
      for (int i = 0; i < TOT; i++) step(1'b0, 1'b1);
      step(1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule